// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps the undo log for register renaming in an out-of-order core. Each time the rename stage gives an instruction's destination a fresh physical register, it pushes one record. The record holds the instruction's sequence number, the architectural register, the newly granted physical register and the physical register it displaced. An instruction without a destination still pushes a single placeholder record that carries only its sequence number.

Two requests shrink the log. A squash request names a sequence number. The block then walks back from the youngest record and removes every record younger than that number. For each real record it removed, it issues one write that restores the rename map and one return to the free list. A commit request also names a sequence number. The block then drains from the oldest record up to and including that instruction, and returns each displaced register to the free list. Both walks take one record per clock. While either walk is pending, `busy` stays high and pushes are refused. The rename map table and the free list sit outside the block and consume the two strobed outputs.

Top module: `rename_hist_buf`

## Requirements
- R1: After a synchronous active-low reset the log is empty, `busy` is low, `push_ready` is high and both `map_wr_valid` and `free_valid` are low.
- R2: A record is stored when `push_valid` and `push_ready` are both high on a clock edge. `push_ready` is low while `busy` is high or while DEPTH records are held.
- R3: A squash request for sequence S removes every record whose sequence number is younger than S, one record per cycle, starting from the youngest. Younger means that (seq − S), taken as a signed SEQ_W-bit value, is greater than zero. Records from the same instruction are handled alike.
- R4: For each record removed by a squash that is not a placeholder, one cycle carries both writes. `map_wr_valid` is high with `map_wr_areg` = its architectural register and `map_wr_preg` = its displaced register. `free_valid` is high with `free_preg` = its new register.
- R5: A commit request for sequence N removes records from the oldest end while the oldest record is not younger than N, one per cycle. For each removed record that is not a placeholder, `free_valid` is high with `free_preg` = its displaced register, and `map_wr_valid` stays low.
- R6: If the oldest record is already younger than N, a commit request removes nothing and produces no strobe.
- R7: A squash request while the log is empty produces no strobe and leaves the log empty.
- R8: A placeholder record is removed by a walk like any other record and uses one cycle, but it produces no strobe.
- R9: Strobes appear only as the result of a walk. Each strobe appears on the cycle after the edge that removed its record.
- R10: `busy` is high from the edge that accepts a request until the walk ends. If squash and commit work are both pending, the squash walk runs first.
- R11: Every sequence comparison uses wrap-aware subtraction, so a walk across the wrap of the sequence counter removes exactly the younger or older records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Record offered by rename |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly granted physical register |
| push_old_preg | input | PREG_W | Physical register that was displaced |
| push_placeholder | input | 1 | Record stands for an instruction with no destination |
| push_ready | output | 1 | Block can take a record this cycle |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Sequence number of the youngest committed instruction |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Records younger than this are undone |
| busy | output | 1 | A walk is pending or running |
| map_wr_valid | output | 1 | Rename map restore strobe |
| map_wr_areg | output | AREG_W | Map entry to restore |
| map_wr_preg | output | PREG_W | Physical register written back into that entry |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register handed back |

## Verification
The bound checker watches the following on every cycle:
- The push gate against `busy` and against occupancy.
- The occupancy step on each accepted push.
- The pairing of a map write with a free return.
- That every strobe follows a cycle in which a walk was pending, and that it matches a one-record drop in occupancy.

Only the bench scenarios can show the rest:
- Which records a walk selects, and in what order.
- That the values returned are the new register on a squash and the displaced register on a commit.
- That placeholders stay silent.
- That an ignored commit or a squash on an empty log leaves the contents intact.
- That the squash walk runs before the commit walk.
- That comparisons hold across the sequence wrap.

// File: rtl/rhb_pkg.sv
// Shared definitions for the rename history buffer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rhb_pkg;

    // Which walk the engine is performing in the current cycle.
    typedef enum logic [1:0] {
        WALK_NONE   = 2'd0,
        WALK_SQUASH = 2'd1,
        WALK_COMMIT = 2'd2
    } walk_mode_e;

endpackage

// File: rtl/rhb_store.sv
// Circular record store of the rename history buffer.
// Pushes enter at the young end. Records leave from the young end (rollback)
// or from the old end (retire).
// Assumes: DEPTH is a power of two. At most one of push, pop_young and
// pop_old is high in a cycle (guaranteed by the caller), and no pop is
// requested while empty and no push while full.
module rhb_store #(
    parameter int DEPTH = 32,
    parameter int REC_W = 37
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [REC_W-1:0]           push_rec,
    input  logic                       pop_young,
    input  logic                       pop_old,
    output logic [REC_W-1:0]           young_rec,
    output logic [REC_W-1:0]           old_rec,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [REC_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head_q;   // slot of the oldest record
    logic [PTR_W-1:0] tail_q;   // slot the next push fills
    logic [PTR_W-1:0] tail_m1;

    assign tail_m1   = tail_q - PTR_W'(1);
    assign young_rec = mem[tail_m1];
    assign old_rec   = mem[head_q];
    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);

    // Record array write port; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_q] <= push_rec;
        end
    end

    // Pointer and occupancy bookkeeping for the three operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else if (push) begin
            tail_q <= tail_q + PTR_W'(1);
            count  <= count + CNT_W'(1);
        end else if (pop_young) begin
            tail_q <= tail_m1;
            count  <= count - CNT_W'(1);
        end else if (pop_old) begin
            head_q <= head_q + PTR_W'(1);
            count  <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rhb_walk.sv
// Walk engine: latches squash and commit requests and, one record per
// cycle, decides which end of the store to pop and what to emit.
// Assumes: sequence numbers wrap modulo 2**SEQ_W and live records span
// less than half of that range.
module rhb_walk
    import rhb_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 6,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              empty,
    input  logic [SEQ_W-1:0]  y_seq,
    input  logic [AREG_W-1:0] y_areg,
    input  logic [PREG_W-1:0] y_new,
    input  logic [PREG_W-1:0] y_old,
    input  logic              y_ph,
    input  logic [SEQ_W-1:0]  o_seq,
    input  logic [PREG_W-1:0] o_old,
    input  logic              o_ph,
    output logic              busy,
    output logic              pop_young,
    output logic              pop_old,
    output logic              emit_map,
    output logic [AREG_W-1:0] emit_areg,
    output logic [PREG_W-1:0] emit_map_preg,
    output logic              emit_free,
    output logic [PREG_W-1:0] emit_free_preg
);
    // True when a is strictly younger than b under wrap-aware ordering.
    function automatic logic younger(input logic [SEQ_W-1:0] a,
                                     input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (!d[SEQ_W-1]) && (d != '0);
    endfunction

    logic             sq_pend_q, cm_pend_q;
    logic [SEQ_W-1:0] sq_tgt_q,  cm_tgt_q;
    logic             sq_hit, cm_hit;
    walk_mode_e       mode;

    assign busy = sq_pend_q | cm_pend_q;

    // Select the active walk; squash work always goes first.
    always_comb begin
        if (sq_pend_q)      mode = WALK_SQUASH;
        else if (cm_pend_q) mode = WALK_COMMIT;
        else                mode = WALK_NONE;
    end

    assign sq_hit = !empty && younger(y_seq, sq_tgt_q);
    assign cm_hit = !empty && !younger(o_seq, cm_tgt_q);

    // Per-cycle pop and emit decision for the active walk.
    always_comb begin
        pop_young      = 1'b0;
        pop_old        = 1'b0;
        emit_map       = 1'b0;
        emit_free      = 1'b0;
        emit_areg      = y_areg;
        emit_map_preg  = y_old;
        emit_free_preg = y_new;
        unique case (mode)
            WALK_SQUASH: begin
                pop_young = sq_hit;
                emit_map  = sq_hit && !y_ph;
                emit_free = sq_hit && !y_ph;
            end
            WALK_COMMIT: begin
                pop_old        = cm_hit;
                emit_free      = cm_hit && !o_ph;
                emit_free_preg = o_old;
            end
            default: ;
        endcase
    end

    // Squash request latch; a second request keeps the older target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_pend_q <= 1'b0;
            sq_tgt_q  <= '0;
        end else if (squash_valid) begin
            sq_pend_q <= 1'b1;
            if (!(sq_pend_q && younger(squash_seq, sq_tgt_q))) begin
                sq_tgt_q <= squash_seq;
            end
        end else if (mode == WALK_SQUASH && !sq_hit) begin
            sq_pend_q <= 1'b0;
        end
    end

    // Commit request latch; a second request keeps the younger target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_pend_q <= 1'b0;
            cm_tgt_q  <= '0;
        end else if (commit_valid) begin
            cm_pend_q <= 1'b1;
            if (!(cm_pend_q && younger(cm_tgt_q, commit_seq))) begin
                cm_tgt_q <= commit_seq;
            end
        end else if (mode == WALK_COMMIT && !cm_hit) begin
            cm_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rhb_emit.sv
// Output register stage for the map-restore and free-list strobes.
// Assumes: the walk engine raises at most one of each strobe per cycle.
module rhb_emit #(
    parameter int AREG_W = 6,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_map,
    input  logic [AREG_W-1:0] in_areg,
    input  logic [PREG_W-1:0] in_map_preg,
    input  logic              in_free,
    input  logic [PREG_W-1:0] in_free_preg,
    output logic              map_wr_valid,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);
    // Register both strobes with their payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_wr_valid <= 1'b0;
            map_wr_areg  <= '0;
            map_wr_preg  <= '0;
            free_valid   <= 1'b0;
            free_preg    <= '0;
        end else begin
            map_wr_valid <= in_map;
            map_wr_areg  <= in_areg;
            map_wr_preg  <= in_map_preg;
            free_valid   <= in_free;
            free_preg    <= in_free_preg;
        end
    end

endmodule

// File: rtl/rename_hist_buf.sv
// Rename history buffer: an ordered undo log of register renames, with a
// rollback walk (squash) and a retire walk (commit), one record per cycle.
// Assumes: the rename stage pushes in program order, and sequence numbers
// of live records span less than half the sequence range.
module rename_hist_buf #(
    parameter int DEPTH  = 32,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 6,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_old_preg,
    input  logic              push_placeholder,
    output logic              push_ready,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              busy,
    output logic              map_wr_valid,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);
    localparam int REC_W  = SEQ_W + AREG_W + 2 * PREG_W + 1;
    localparam int CNT_W  = $clog2(DEPTH) + 1;
    // Field offsets inside a packed record {seq, areg, new, old, ph}.
    localparam int OFF_OLD  = 1;
    localparam int OFF_NEW  = OFF_OLD + PREG_W;
    localparam int OFF_AREG = OFF_NEW + PREG_W;
    localparam int OFF_SEQ  = OFF_AREG + AREG_W;

    logic [REC_W-1:0] push_rec, young_rec, old_rec;
    logic [CNT_W-1:0] occ;
    logic             full, empty, push_fire;
    logic             pop_young, pop_old;
    logic             emit_map, emit_free;
    logic [AREG_W-1:0] emit_areg;
    logic [PREG_W-1:0] emit_map_preg, emit_free_preg;

    assign push_ready = !busy && !full;
    assign push_fire  = push_valid && push_ready;
    assign push_rec   = {push_seq, push_areg, push_new_preg, push_old_preg,
                         push_placeholder};

    rhb_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_fire),
        .push_rec  (push_rec),
        .pop_young (pop_young),
        .pop_old   (pop_old),
        .young_rec (young_rec),
        .old_rec   (old_rec),
        .count     (occ),
        .full      (full),
        .empty     (empty)
    );

    rhb_walk #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .squash_valid   (squash_valid),
        .squash_seq     (squash_seq),
        .commit_valid   (commit_valid),
        .commit_seq     (commit_seq),
        .empty          (empty),
        .y_seq          (young_rec[OFF_SEQ +: SEQ_W]),
        .y_areg         (young_rec[OFF_AREG +: AREG_W]),
        .y_new          (young_rec[OFF_NEW +: PREG_W]),
        .y_old          (young_rec[OFF_OLD +: PREG_W]),
        .y_ph           (young_rec[0]),
        .o_seq          (old_rec[OFF_SEQ +: SEQ_W]),
        .o_old          (old_rec[OFF_OLD +: PREG_W]),
        .o_ph           (old_rec[0]),
        .busy           (busy),
        .pop_young      (pop_young),
        .pop_old        (pop_old),
        .emit_map       (emit_map),
        .emit_areg      (emit_areg),
        .emit_map_preg  (emit_map_preg),
        .emit_free      (emit_free),
        .emit_free_preg (emit_free_preg)
    );

    rhb_emit #(.AREG_W(AREG_W), .PREG_W(PREG_W)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_map       (emit_map),
        .in_areg      (emit_areg),
        .in_map_preg  (emit_map_preg),
        .in_free      (emit_free),
        .in_free_preg (emit_free_preg),
        .map_wr_valid (map_wr_valid),
        .map_wr_areg  (map_wr_areg),
        .map_wr_preg  (map_wr_preg),
        .free_valid   (free_valid),
        .free_preg    (free_preg)
    );

endmodule

// File: rtl/rhb_checker.sv
// Property checker for rename_hist_buf, attached by bind.
// Assumes: count is the top's internal occupancy signal.
module rhb_checker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_ready,
    input logic             busy,
    input logic             map_wr_valid,
    input logic             free_valid,
    input logic [CNT_W-1:0] count
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && push_ready && !free_valid && !map_wr_valid)); // R1

    AST_BUSY_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push_ready); // R2

    AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !push_ready); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |=> (count == $past(count) + CNT_W'(1))); // R2

    AST_MAP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> free_valid); // R4

    AST_STROBE_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid || map_wr_valid) |-> $past(busy)); // R9

    AST_STROBE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> (count + CNT_W'(1) == $past(count))); // R3

endmodule

bind rename_hist_buf rhb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .busy         (busy),
    .map_wr_valid (map_wr_valid),
    .free_valid   (free_valid),
    .count        (occ)
);

// File: tb/rename_hist_buf_tb.sv
// Self-checking bench: table-driven pushes, then directed walk scenarios.
module rename_hist_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_seq = '0;
    logic [5:0]  push_areg = '0;
    logic [6:0]  push_new_preg = '0;
    logic [6:0]  push_old_preg = '0;
    logic        push_placeholder = 1'b0;
    logic        push_ready;
    logic        commit_valid = 1'b0;
    logic [15:0] commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [15:0] squash_seq = '0;
    logic        busy;
    logic        map_wr_valid;
    logic [5:0]  map_wr_areg;
    logic [6:0]  map_wr_preg;
    logic        free_valid;
    logic [6:0]  free_preg;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Strobe events captured during one walk.
    int   ev_n;
    logic ev_mv [64];
    int   ev_ma [64];
    int   ev_mp [64];
    logic ev_fv [64];
    int   ev_fp [64];

    always #5 clk = ~clk;

    rename_hist_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
        .push_new_preg(push_new_preg), .push_old_preg(push_old_preg),
        .push_placeholder(push_placeholder), .push_ready(push_ready),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .busy(busy), .map_wr_valid(map_wr_valid), .map_wr_areg(map_wr_areg),
        .map_wr_preg(map_wr_preg), .free_valid(free_valid), .free_preg(free_preg)
    );

    // Vector: {seq, areg, new, old, placeholder, expected push_ready}.
    localparam logic [37:0] PUSH_TAB [6] = '{
        {16'd10, 6'd1, 7'd40, 7'd1,  1'b0, 1'b1},
        {16'd11, 6'd2, 7'd41, 7'd2,  1'b0, 1'b1},
        {16'd11, 6'd3, 7'd42, 7'd3,  1'b0, 1'b1},
        {16'd12, 6'd0, 7'd0,  7'd0,  1'b1, 1'b1},
        {16'd13, 6'd1, 7'd43, 7'd40, 1'b0, 1'b1},
        {16'd14, 6'd4, 7'd44, 7'd4,  1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one record at a negedge; report whether it was ready.
    task automatic do_push(input logic [15:0] s, input logic [5:0] a,
                           input logic [6:0] np, input logic [6:0] op,
                           input logic ph, output logic rdy);
        push_valid = 1'b1; push_seq = s; push_areg = a;
        push_new_preg = np; push_old_preg = op; push_placeholder = ph;
        rdy = push_ready;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // Issue requests, then capture strobes until busy drops.
    task automatic walk(input logic sq, input logic [15:0] sqs,
                        input logic cm, input logic [15:0] cms);
        squash_valid = sq; squash_seq = sqs;
        commit_valid = cm; commit_seq = cms;
        @(negedge clk);
        squash_valid = 1'b0; commit_valid = 1'b0;
        chk("R10 busy after request", int'(busy), 1);
        ev_n = 0;
        for (int g = 0; g < 200; g++) begin
            if (free_valid || map_wr_valid) begin
                ev_mv[ev_n] = map_wr_valid; ev_ma[ev_n] = int'(map_wr_areg);
                ev_mp[ev_n] = int'(map_wr_preg);
                ev_fv[ev_n] = free_valid; ev_fp[ev_n] = int'(free_preg);
                if (ev_n < 63) ev_n++;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic rdy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 push_ready", int'(push_ready), 1);
        chk("R1 strobes", int'(free_valid | map_wr_valid), 0);

        // R2: table walk of pushes
        for (int i = 0; i < 6; i++) begin
            do_push(PUSH_TAB[i][37:22], PUSH_TAB[i][21:16], PUSH_TAB[i][15:9],
                    PUSH_TAB[i][8:2], PUSH_TAB[i][1], rdy);
            chk("R2 push accepted", int'(rdy), int'(PUSH_TAB[i][0]));
        end

        // R6: commit older than oldest record is ignored
        walk(1'b0, 16'd0, 1'b1, 16'd9);
        chk("R6 no strobes", ev_n, 0);

        // R3/R4: squash 12 undoes seq 14 then 13
        walk(1'b1, 16'd12, 1'b0, 16'd0);
        chk("R3 squash count", ev_n, 2);
        chk("R4 ev0 map areg", ev_ma[0], 4);
        chk("R4 ev0 map preg", ev_mp[0], 4);
        chk("R4 ev0 free", ev_fp[0], 44);
        chk("R4 ev1 map areg", ev_ma[1], 1);
        chk("R4 ev1 map preg", ev_mp[1], 40);
        chk("R4 ev1 free", ev_fp[1], 43);
        chk("R4 paired", int'(ev_mv[1] & ev_fv[1]), 1);

        // R5: commit 11 drains seq 10, 11, 11
        walk(1'b0, 16'd0, 1'b1, 16'd11);
        chk("R5 commit count", ev_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R5 freed displaced", ev_fp[k], k + 1);
            chk("R5 no map write", int'(ev_mv[k]), 0);
        end

        // R8: placeholder seq 12 removed silently
        walk(1'b1, 16'd11, 1'b0, 16'd0);
        chk("R8 placeholder silent", ev_n, 0);
        // R7: squash on empty log
        walk(1'b1, 16'd0, 1'b0, 16'd0);
        chk("R7 empty squash silent", ev_n, 0);

        // R2/R8/R11: fill across the sequence wrap; log must hold DEPTH
        for (int i = 0; i < 32; i++) begin
            do_push(16'(65520 + i), 6'(i), 7'(i), 7'(64 + i), 1'b0, rdy);
            chk("R8 R2 fill accepted", int'(rdy), 1);
        end
        chk("R2 full refuses", int'(push_ready), 0);
        do_push(16'd16, 6'd9, 7'd9, 7'd9, 1'b0, rdy);
        chk("R2 full push refused", int'(rdy), 0);

        // R11: squash 65535 removes seq 0..15 (16 records)
        walk(1'b1, 16'd65535, 1'b0, 16'd0);
        chk("R11 squash wrap count", ev_n, 16);
        for (int k = 0; k < 16; k++) begin
            chk("R11 squash free", ev_fp[k], 31 - k);
            chk("R11 squash map", ev_mp[k], 95 - k);
        end
        // R11: commit 65535 drains the remaining 16 from the oldest
        walk(1'b0, 16'd0, 1'b1, 16'd65535);
        chk("R11 commit wrap count", ev_n, 16);
        for (int k = 0; k < 16; k++) begin
            chk("R11 commit free", ev_fp[k], 64 + k);
        end

        // R10: squash and commit together; squash walk goes first
        do_push(16'd100, 6'd5, 7'd10, 7'd20, 1'b0, rdy);
        do_push(16'd101, 6'd6, 7'd11, 7'd21, 1'b0, rdy);
        do_push(16'd102, 6'd7, 7'd12, 7'd22, 1'b0, rdy);
        walk(1'b1, 16'd100, 1'b1, 16'd102);
        chk("R10 event count", ev_n, 3);
        chk("R10 first map areg", ev_ma[0], 7);
        chk("R10 first free", ev_fp[0], 12);
        chk("R10 second free", ev_fp[1], 11);
        chk("R10 commit last no map", int'(ev_mv[2]), 0);
        chk("R10 commit last free", ev_fp[2], 20);
        chk("R10 idle after walks", int'(busy), 0);
        chk("R9 no strobe when idle", int'(free_valid | map_wr_valid), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule